// File: doc/BRIEF.md
# Comma-Based Word Aligner

This block sits behind a deserializer that delivers 10-bit words with an unknown framing. Each word clock it joins the incoming word with the one before it into a 20-bit window. It compares every one of the ten possible starting positions in that window against the comma pattern, in both disparity forms, and applies a per-bit mask. A barrel shifter then cuts out the 10-bit slice that starts at the chosen offset. All of this logic runs at the parallel word clock.

A three-state controller owns the offset. It hunts for a comma, checks that further commas keep arriving at the same position, and then declares lock. Framed words leave the block only while it is locked. Once locked, a comma at any other position counts as a framing error. A leaky error counter sends the controller back to hunting only when such errors come close together. Line decoding and descrambling belong to later stages.

Serial order convention: bit 0 of every word is the earliest bit on the line. In the window, bits 0..9 hold the previous word and bits 10..19 hold the current word.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `word_vld_o` is 0 and `word_o` is 0.
- R2: While locked, `word_o` takes the window slice starting at the locked offset, one register after the window is formed. The bench sees each framed word as the word pushed 1 word earlier, or 2 when the slip is zero. The offset does not change while lock is held.
- R3: A comma is recognised in either form, 10'h17C or 10'h283 (written with bit 0 as the first serial bit), and the two forms may be mixed.
- R4: Lock is declared on the clock that takes in the VERIFY_N-th consecutive comma at the selected offset (3 by default). On that same clock `word_vld_o` rises and `word_o` carries the comma.
- R5: Until lock is declared, `word_vld_o` is 0 and `word_o` is 0. Fewer than VERIFY_N commas at one offset never produce lock.
- R6: During verification, a comma at a different offset drops the controller back to hunting. That comma is not adopted, so VERIFY_N further commas are needed to reach lock.
- R7: While locked, each comma at another offset adds one to an error count. Reaching ERR_LIMIT errors returns the controller to hunting and clears `word_vld_o` on the same clock.
- R8: While locked, every LEAK_N-th comma at the locked offset lowers the error count by one, never below zero.
- R9: Comparator bits whose COMMA_MASK bit is 0 are ignored, so a comma that differs only in those bits still counts.
- R10: Every offset from 0 to 9 can be selected. When several offsets match in the same clock, the lowest one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_word_i | input | 10 | Unframed word from the deserializer, bit 0 earliest |
| word_o | output | 10 | Framed word, zero while not locked |
| word_vld_o | output | 1 | High while lock is held |

## Verification
The bench builds the aligner with ERR_LIMIT = 3, LEAK_N = 4 and COMMA_MASK = 10'h1FF. With these values, realignment after a burst of misplaced commas and the leak that forgives an earlier error both happen within a few dozen words. The mask setting lets a comma with its last serial bit flipped show that masked bits are ignored. VERIFY_N stays at 3, and the stimulus slips the stream to six different offsets, both comma forms included.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  typedef enum logic [1:0] {
    AL_HUNT   = 2'd0,
    AL_CHECK  = 2'd1,
    AL_LOCKED = 2'd2
  } align_state_e;
endpackage

// File: rtl/comma_match_bank.sv
module comma_match_bank #(
  parameter int            W          = 10,
  parameter logic [W-1:0]  COMMA_A    = 10'h17C,
  parameter logic [W-1:0]  COMMA_B    = 10'h283,
  parameter logic [W-1:0]  COMMA_MASK = '1
) (
  input  logic [2*W-1:0] win_i,
  output logic [W-1:0]   hit_o
);
  // one masked comparator pair per starting bit position
  for (genvar g = 0; g < W; g++) begin : g_cmp
    logic [W-1:0] cand;
    assign cand     = win_i[g +: W];
    assign hit_o[g] = (((cand ^ COMMA_A) & COMMA_MASK) == '0) ||
                      (((cand ^ COMMA_B) & COMMA_MASK) == '0);
  end
endmodule

// File: rtl/slice_select.sv
module slice_select #(
  parameter int W     = 10,
  localparam int OFF_W = $clog2(W)
) (
  input  logic [2*W-1:0] win_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [W-1:0]   slice_o
);
  logic [W-1:0] cand [W];

  for (genvar g = 0; g < W; g++) begin : g_tap
    assign cand[g] = win_i[g +: W];
  end

  always_comb begin
    slice_o = '0;
    for (int i = 0; i < W; i++) begin
      if (off_i == OFF_W'(i)) slice_o = cand[i];
    end
  end
endmodule

// File: rtl/align_fsm.sv
module align_fsm
  import aligner_pkg::*;
#(
  parameter int W         = 10,
  parameter int VERIFY_N  = 3,
  parameter int ERR_LIMIT = 4,
  parameter int LEAK_N    = 16,
  localparam int OFF_W  = $clog2(W),
  localparam int VCNT_W = $clog2(VERIFY_N + 1),
  localparam int ERR_W  = $clog2(ERR_LIMIT + 1),
  localparam int GOOD_W = $clog2(LEAK_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      hit_i,
  output logic [OFF_W-1:0]  off_nxt_o,
  output logic              lock_nxt_o,
  output align_state_e      state_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [VCNT_W-1:0] vcnt_o,
  output logic [ERR_W-1:0]  err_o
);
  align_state_e      state_q, state_d;
  logic [OFF_W-1:0]  off_q, off_d, first_hit;
  logic [VCNT_W-1:0] vcnt_q, vcnt_d;
  logic [ERR_W-1:0]  err_q, err_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [W-1:0]      at_off;
  logic              on_spot, elsewhere;

  // lowest matching offset wins
  always_comb begin
    first_hit = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit_i[i]) first_hit = OFF_W'(i);
    end
  end

  assign at_off    = W'(1) << off_q;
  assign on_spot   = |(hit_i & at_off);
  assign elsewhere = |(hit_i & ~at_off);

  always_comb begin
    state_d = state_q;
    off_d   = off_q;
    vcnt_d  = vcnt_q;
    err_d   = err_q;
    good_d  = good_q;
    unique case (state_q)
      AL_HUNT: begin
        if (|hit_i) begin
          state_d = AL_CHECK;
          off_d   = first_hit;
          vcnt_d  = VCNT_W'(1);
        end
      end
      AL_CHECK: begin
        if (on_spot) begin
          if (vcnt_q == VCNT_W'(VERIFY_N - 1)) begin
            state_d = AL_LOCKED;
            err_d   = '0;
            good_d  = '0;
          end else begin
            vcnt_d = vcnt_q + VCNT_W'(1);
          end
        end else if (elsewhere) begin
          state_d = AL_HUNT;
          vcnt_d  = '0;
        end
      end
      AL_LOCKED: begin
        if (on_spot) begin
          if (good_q == GOOD_W'(LEAK_N - 1)) begin
            good_d = '0;
            if (err_q != '0) err_d = err_q - ERR_W'(1);
          end else begin
            good_d = good_q + GOOD_W'(1);
          end
        end else if (elsewhere) begin
          if (err_q == ERR_W'(ERR_LIMIT - 1)) begin
            state_d = AL_HUNT;
            err_d   = '0;
            vcnt_d  = '0;
          end else begin
            err_d = err_q + ERR_W'(1);
          end
        end
      end
      default: state_d = AL_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AL_HUNT;
      off_q   <= '0;
      vcnt_q  <= '0;
      err_q   <= '0;
      good_q  <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      vcnt_q  <= vcnt_d;
      err_q   <= err_d;
      good_q  <= good_d;
    end
  end

  assign off_nxt_o  = off_d;
  assign lock_nxt_o = (state_d == AL_LOCKED);
  assign state_o    = state_q;
  assign off_o      = off_q;
  assign vcnt_o     = vcnt_q;
  assign err_o      = err_q;
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import aligner_pkg::*;
#(
  parameter int            W          = 10,
  parameter logic [W-1:0]  COMMA_A    = 10'h17C,
  parameter logic [W-1:0]  COMMA_B    = 10'h283,
  parameter logic [W-1:0]  COMMA_MASK = '1,
  parameter int            VERIFY_N   = 3,
  parameter int            ERR_LIMIT  = 4,
  parameter int            LEAK_N     = 16,
  localparam int OFF_W  = $clog2(W),
  localparam int VCNT_W = $clog2(VERIFY_N + 1),
  localparam int ERR_W  = $clog2(ERR_LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_word_i,
  output logic [W-1:0] word_o,
  output logic         word_vld_o
);
  logic [W-1:0]      prev_q;
  logic [2*W-1:0]    window;
  logic [W-1:0]      hit;
  logic [OFF_W-1:0]  off_nxt;
  logic              lock_nxt;
  logic [W-1:0]      slice;
  logic [W-1:0]      word_q;
  logic              vld_q;
  align_state_e      fsm_state;
  logic [OFF_W-1:0]  fsm_off;
  logic [VCNT_W-1:0] fsm_vcnt;
  logic [ERR_W-1:0]  fsm_err;

  assign window = {rx_word_i, prev_q};

  comma_match_bank #(
    .W(W), .COMMA_A(COMMA_A), .COMMA_B(COMMA_B), .COMMA_MASK(COMMA_MASK)
  ) u_bank (
    .win_i (window),
    .hit_o (hit)
  );

  align_fsm #(
    .W(W), .VERIFY_N(VERIFY_N), .ERR_LIMIT(ERR_LIMIT), .LEAK_N(LEAK_N)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .off_nxt_o  (off_nxt),
    .lock_nxt_o (lock_nxt),
    .state_o    (fsm_state),
    .off_o      (fsm_off),
    .vcnt_o     (fsm_vcnt),
    .err_o      (fsm_err)
  );

  slice_select #(.W(W)) u_shift (
    .win_i   (window),
    .off_i   (off_nxt),
    .slice_o (slice)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= rx_word_i;
      word_q <= lock_nxt ? slice : '0;
      vld_q  <= lock_nxt;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/comma_word_aligner_chk.sv
module comma_word_aligner_chk
  import aligner_pkg::*;
#(
  parameter int W         = 10,
  parameter int VERIFY_N  = 3,
  parameter int ERR_LIMIT = 4,
  localparam int OFF_W  = $clog2(W),
  localparam int VCNT_W = $clog2(VERIFY_N + 1),
  localparam int ERR_W  = $clog2(ERR_LIMIT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vld,
  input logic [W-1:0]      word,
  input align_state_e      state,
  input logic [OFF_W-1:0]  off,
  input logic [VCNT_W-1:0] vcnt,
  input logic [ERR_W-1:0]  err
);
  p_gated_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> word == '0);

  p_valid_only_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> state == AL_LOCKED);

  p_lock_after_check_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> ($past(state) == AL_CHECK) && ($past(vcnt) == VCNT_W'(VERIFY_N - 1)));

  p_offset_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AL_LOCKED && $past(state) == AL_LOCKED) |-> $stable(off));

  p_offset_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(off) < W);

  p_err_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(err) < ERR_LIMIT);
endmodule

bind comma_word_aligner comma_word_aligner_chk #(
  .W(W), .VERIFY_N(VERIFY_N), .ERR_LIMIT(ERR_LIMIT)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .vld   (word_vld_o),
  .word  (word_o),
  .state (fsm_state),
  .off   (fsm_off),
  .vcnt  (fsm_vcnt),
  .err   (fsm_err)
);

// File: tb/comma_word_aligner_test.sv
module comma_word_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] CM = 10'h17C;  // negative-disparity comma
  localparam logic [9:0] CP = 10'h283;  // positive-disparity comma
  localparam logic [9:0] D1 = 10'h333;
  localparam logic [9:0] D2 = 10'h155;
  localparam logic [9:0] D3 = 10'h2AA;
  localparam logic [9:0] MA = 10'h395;  // misplaced comma, first half
  localparam logic [9:0] MB = 10'h2AB;  // misplaced comma, second half
  // {comma form, slip}: form 1 selects CP
  localparam logic [4:0] TBL [6] = '{5'h00, 5'h13, 5'h05, 5'h19, 5'h01, 5'h17};

  logic clk = 1'b0;
  logic rst_n;
  logic [9:0] rx;
  logic [9:0] word;
  logic vld;

  int checks = 0;
  int errors = 0;
  int slip = 0;
  int n = 0;
  logic [9:0] last;
  logic [9:0] hist [64];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comma_word_aligner #(
    .COMMA_MASK(10'h1FF), .VERIFY_N(3), .ERR_LIMIT(3), .LEAK_N(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rx_word_i(rx), .word_o(word), .word_vld_o(vld)
  );

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s valid actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst_n = 1'b0;
    rx = '0;
    last = '0;
    n = 0;
    slip = s;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one aligned word through the slipping line model
  task automatic push(input logic [9:0] w);
    logic [19:0] cat;
    cat = {w, last};
    rx = cat[slip +: 10];
    last = w;
    hist[n % 64] = w;
    n++;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [9:0] expect_word(input int back);
    return hist[(n - 1 - back) % 64];
  endfunction

  task automatic lock_seq(input logic [9:0] c);
    for (int k = 0; k < 3; k++) begin
      push(c); push(D1); push(D2);
    end
  endtask

  task automatic err_pair();
    push(D1); push(MA); push(MB); push(D1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx = '0;
    last = '0;
    #(CLK_PERIOD * 2 + 1);
    chk_bit("R1 in reset", vld, 1'b0);
    chk_word("R1 in reset", word, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R1 after release", vld, 1'b0);
    chk_word("R1 after release", word, 10'h000);

    // table of slips and comma forms (R2 R3 R4 R10)
    for (int e = 0; e < 6; e++) begin
      logic [9:0] seq [12];
      logic [9:0] c;
      int lat;
      do_reset(int'(TBL[e][3:0]));
      c = TBL[e][4] ? CP : CM;
      lat = (slip == 0) ? 2 : 1;
      seq = '{c, D1, D2, c, D1, D2, c, D3, D1, D2, D3, D1};
      for (int k = 0; k < 12; k++) begin
        push(seq[k]);
        if (k == 5 + lat) chk_bit("R4 before third comma", vld, 1'b0);
        if (k == 6 + lat) begin
          chk_bit("R4 lock on third comma", vld, 1'b1);
          chk_word("R4 R10 comma framed", word, c);
        end
        if (k == 11) chk_word("R2 R3 framed data", word, expect_word(lat));
      end
    end

    // mixed forms still lock (R3)
    do_reset(8);
    push(CM); push(D1); push(D2); push(CP); push(D1); push(D2); push(CM); push(D3);
    chk_bit("R3 mixed forms lock", vld, 1'b1);
    chk_word("R3 mixed framed", word, expect_word(1));

    // two commas never lock (R5)
    do_reset(3);
    push(CM); push(D1); push(D2); push(CM);
    for (int k = 0; k < 8; k++) push(k[0] ? D1 : D2);
    chk_bit("R5 two commas no lock", vld, 1'b0);
    chk_word("R5 word held at zero", word, 10'h000);

    // misplaced comma during verify restarts hunting (R6)
    do_reset(2);
    push(CM); push(D1); push(D2); push(D1);
    slip = 6;
    push(D2); push(D1);
    lock_seq(CM);
    push(D1); push(D2);
    chk_bit("R6 restart needs fresh commas", vld, 1'b0);
    push(CM); push(D1); push(D2);
    chk_bit("R6 lock after restart", vld, 1'b1);
    chk_word("R6 framed at new offset", word, expect_word(1));

    // error threshold (R7)
    do_reset(4);
    lock_seq(CM);
    chk_bit("R7 locked before errors", vld, 1'b1);
    err_pair(); err_pair();
    chk_bit("R7 two errors keep lock", vld, 1'b1);
    chk_word("R7 data still framed", word, expect_word(1));
    err_pair(); push(D2);
    chk_bit("R7 third error drops lock", vld, 1'b0);
    chk_word("R7 word zero after loss", word, 10'h000);

    // leak of the error count (R8)
    do_reset(5);
    lock_seq(CP);
    err_pair(); err_pair();
    for (int k = 0; k < 4; k++) begin
      push(CP); push(D1); push(D2);
    end
    err_pair(); push(D2);
    chk_bit("R8 leak keeps lock", vld, 1'b1);
    err_pair(); push(D2);
    chk_bit("R8 count resumes after leak", vld, 0);

    // masked bit ignored (R9)
    do_reset(7);
    lock_seq(CM ^ 10'h200);
    chk_bit("R9 masked comma locks", vld, 1'b1);
    chk_word("R9 framed data", word, expect_word(1));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule